// File: doc/BRIEF.md
# Decode-stage branch resolver

This block decides conditional branches in the decode stage of a five-stage in-order pipeline. It holds the program counter and the fetch/decode pipeline register. It compares the two register operands read in decode and forms the branch target with an adder of its own. When a branch is taken, it steers the next fetch to the target.

Fetch always assumes the branch is not taken and keeps requesting sequential words. If the branch in decode turns out taken, the word fetched behind it is replaced by an all-zero no-op on the same edge that loads the target into the program counter. A taken branch therefore costs one bubble, and a branch that is not taken costs none. Forwarding into the comparator, delay slots and dynamic prediction are not part of this block.

Top module: `branch_id_unit`

## Requirements
- R1: While rst_ni is low, fetch_pc_o equals RESET_PC, id_instr_o is all-zero (a no-op), and redirect_o and flush_o are 0. Reset is asynchronous.
- R2: With no taken branch in decode, fetch_pc_o advances by 4 on every clock, and id_instr_o takes the word that was on fetch_instr_i at that edge.
- R3: An instruction with opcode bits [31:26] equal to 6'h04 (branch-if-equal) asserts redirect_o when id_rs_val_i equals id_rt_val_i.
- R4: An instruction with opcode 6'h05 (branch-if-not-equal) asserts redirect_o when id_rs_val_i differs from id_rt_val_i.
- R5: Branch-if-equal with unequal operands, and branch-if-not-equal with equal operands, leave redirect_o low. The pipeline then continues sequentially with no bubble.
- R6: target_o equals the fetch address of the branch plus 4, plus the sign-extended offset in bits [15:0] shifted left by 2. This holds for zero, positive and most-negative offsets, with modulo 2^ADDR_W arithmetic.
- R7: On the clock edge after redirect_o is high, fetch_pc_o becomes target_o and id_instr_o becomes all-zero, so a taken branch costs exactly one bubble.
- R8: An instruction whose opcode is neither 6'h04 nor 6'h05 never asserts redirect_o, whatever the operand values are.
- R9: flush_o equals redirect_o in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_instr_i | input | 32 | Instruction word returned for fetch_pc_o |
| id_rs_val_i | input | DATA_W | First register operand of the instruction in decode |
| id_rt_val_i | input | DATA_W | Second register operand of the instruction in decode |
| fetch_pc_o | output | ADDR_W | Current fetch address |
| id_instr_o | output | 32 | Instruction held in the fetch/decode register |
| redirect_o | output | 1 | Next-PC select: 1 loads the branch target |
| flush_o | output | 1 | Squash of the fetch/decode register |
| target_o | output | ADDR_W | Branch target computed in decode |

## Verification
The bench builds the block with 32-bit addresses and operands, and with a non-zero RESET_PC of 32'h1000. A non-zero reset address separates the reset value from a cleared register. With 32-bit addresses, the most-negative offset drives the target adder through wrap-around below zero. The same settings let the bench tell a target jump apart from a plain step of 8 bytes, and an offset of zero makes the target coincide with the sequential address while the bubble still appears.

// File: rtl/branch_pkg.sv
package branch_pkg;
  localparam int INSTR_W   = 32;
  localparam int OP_W      = 6;
  localparam int OP_LSB    = 26;
  localparam int OFS_W     = 16;
  localparam int STEP      = INSTR_W / 8;
  localparam logic [OP_W-1:0]    OP_BR_EQ = 6'h04;
  localparam logic [OP_W-1:0]    OP_BR_NE = 6'h05;
  localparam logic [INSTR_W-1:0] NOP_WORD = '0;
endpackage

// File: rtl/bru_fetch_pc.sv
module bru_fetch_pc
  import branch_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] pc_seq_o
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(STEP);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;

  assign pc_seq_o = pc_q + PC_STEP;
  assign pc_d     = take_i ? target_i : pc_seq_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/bru_ifid.sv
module bru_ifid
  import branch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               squash_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  pc_seq_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic [ADDR_W-1:0]  pc_seq_o
);
  logic [INSTR_W-1:0] instr_q;
  logic [ADDR_W-1:0]  pc_seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q  <= NOP_WORD;
      pc_seq_q <= '0;
    end else begin
      // wrong-path word replaced by a no-op
      instr_q  <= squash_i ? NOP_WORD : instr_i;
      pc_seq_q <= pc_seq_i;
    end
  end

  assign instr_o  = instr_q;
  assign pc_seq_o = pc_seq_q;
endmodule

// File: rtl/bru_resolve.sv
module bru_resolve
  import branch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [ADDR_W-1:0] pc_seq_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam int EXT_W = OFS_W + 2;

  logic              is_eq_br;
  logic              is_ne_br;
  logic              ops_equal;
  logic [ADDR_W-1:0] ofs_ext;

  assign is_eq_br  = (opcode_i == OP_BR_EQ);
  assign is_ne_br  = (opcode_i == OP_BR_NE);
  assign ops_equal = (rs_val_i == rt_val_i);
  assign take_o    = (is_eq_br & ops_equal) | (is_ne_br & ~ops_equal);

  generate
    if (ADDR_W > EXT_W) begin : g_sext
      assign ofs_ext = {{(ADDR_W-EXT_W){offset_i[OFS_W-1]}}, offset_i, 2'b00};
    end else begin : g_trunc
      logic [EXT_W-1:0] ofs_sh;
      assign ofs_sh  = {offset_i, 2'b00};
      assign ofs_ext = ofs_sh[ADDR_W-1:0];
    end
  endgenerate

  // dedicated adder: main ALU is busy until execute
  assign target_o = pc_seq_i + ofs_ext;
endmodule

// File: rtl/branch_id_unit.sv
module branch_id_unit
  import branch_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] fetch_instr_i,
  input  logic [DATA_W-1:0]  id_rs_val_i,
  input  logic [DATA_W-1:0]  id_rt_val_i,
  output logic [ADDR_W-1:0]  fetch_pc_o,
  output logic [INSTR_W-1:0] id_instr_o,
  output logic               redirect_o,
  output logic               flush_o,
  output logic [ADDR_W-1:0]  target_o
);
  logic              take;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] if_pc_seq;
  logic [ADDR_W-1:0] id_pc_seq;
  logic [INSTR_W-1:0] id_instr;

  bru_fetch_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .target_i (target),
    .pc_o     (fetch_pc_o),
    .pc_seq_o (if_pc_seq)
  );

  bru_ifid #(.ADDR_W(ADDR_W)) u_ifid (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .squash_i (take),
    .instr_i  (fetch_instr_i),
    .pc_seq_i (if_pc_seq),
    .instr_o  (id_instr),
    .pc_seq_o (id_pc_seq)
  );

  bru_resolve #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_res (
    .opcode_i (id_instr[OP_LSB +: OP_W]),
    .offset_i (id_instr[OFS_W-1:0]),
    .pc_seq_i (id_pc_seq),
    .rs_val_i (id_rs_val_i),
    .rt_val_i (id_rt_val_i),
    .take_o   (take),
    .target_o (target)
  );

  assign id_instr_o = id_instr;
  assign redirect_o = take;
  assign flush_o    = take;
  assign target_o   = target;
endmodule

// File: rtl/branch_id_unit_chk.sv
module branch_id_unit_chk
  import branch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [INSTR_W-1:0] id_instr_o,
  input logic [DATA_W-1:0]  id_rs_val_i,
  input logic [DATA_W-1:0]  id_rt_val_i,
  input logic [ADDR_W-1:0]  fetch_pc_o,
  input logic               redirect_o,
  input logic               flush_o,
  input logic [ADDR_W-1:0]  target_o
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(STEP);

  logic [OP_W-1:0] op;
  assign op = id_instr_o[OP_LSB +: OP_W];

  // R7
  taken_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> fetch_pc_o == $past(target_o));

  // R7
  bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> id_instr_o == NOP_WORD);

  // R2
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |=> fetch_pc_o == $past(fetch_pc_o) + PC_STEP);

  // R8
  nonbranch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_BR_EQ && op != OP_BR_NE) |-> !redirect_o);

  // R5
  not_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op == OP_BR_EQ && id_rs_val_i != id_rt_val_i) ||
     (op == OP_BR_NE && id_rs_val_i == id_rt_val_i)) |-> !redirect_o);

  // R9
  flush_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o == redirect_o);
endmodule

bind branch_id_unit branch_id_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .id_instr_o  (id_instr_o),
  .id_rs_val_i (id_rs_val_i),
  .id_rt_val_i (id_rt_val_i),
  .fetch_pc_o  (fetch_pc_o),
  .redirect_o  (redirect_o),
  .flush_o     (flush_o),
  .target_o    (target_o)
);

// File: tb/branch_id_unit_bench.sv
`timescale 1ns/1ps
module branch_id_unit_bench;
  localparam int          ADDR_W   = 32;
  localparam int          DATA_W   = 32;
  localparam logic [31:0] RST_PC   = 32'h0000_1000;
  localparam logic [31:0] FILLER   = 32'h0043_2020; // opcode 0, not a branch
  localparam int          NVEC     = 9;

  // {instr, rs value, rt value}
  localparam logic [95:0] VEC [NVEC] = '{
    {32'h1022_0003, 32'd7,          32'd7},           // eq branch, equal, +3
    {32'h1022_0005, 32'd7,          32'd8},           // eq branch, unequal
    {32'h1443_FFFE, 32'hDEAD_0000,  32'hDEAD_0001},   // ne branch, unequal, -2
    {32'h1443_0010, 32'h55,         32'h55},          // ne branch, equal
    {32'h0000_0020, 32'd9,          32'd9},           // opcode 0, equal operands
    {32'h8C22_0004, 32'd1,          32'd1},           // opcode 6'h23, equal operands
    {32'h1000_0000, 32'd0,          32'd0},           // eq branch, offset 0
    {32'h1000_8000, 32'hFFFF_FFFF,  32'hFFFF_FFFF},   // eq branch, most-negative
    {32'h1401_7FFF, 32'd0,          32'h8000_0000}    // ne branch, most-positive
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       fetch_instr = FILLER;
  logic [DATA_W-1:0] rs_val = '0;
  logic [DATA_W-1:0] rt_val = '0;
  logic [ADDR_W-1:0] fetch_pc;
  logic [31:0]       id_instr;
  logic              redirect;
  logic              flush;
  logic [ADDR_W-1:0] target;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  branch_id_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_PC(RST_PC)) u_branch_id_unit (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .fetch_instr_i (fetch_instr),
    .id_rs_val_i   (rs_val),
    .id_rt_val_i   (rt_val),
    .fetch_pc_o    (fetch_pc),
    .id_instr_o    (id_instr),
    .redirect_o    (redirect),
    .flush_o       (flush),
    .target_o      (target)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_target(input logic [31:0] pc_f, input logic [31:0] ins);
    return pc_f + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
  endfunction

  function automatic bit exp_take(input logic [31:0] ins, input logic [31:0] a,
                                  input logic [31:0] b);
    return (ins[31:26] == 6'h04 && a == b) || (ins[31:26] == 6'h05 && a != b);
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pc_f;
    logic [31:0] ins;
    logic [31:0] tgt;
    bit          tk;

    // R1 reset state
    repeat (2) @(negedge clk);
    check(fetch_pc == RST_PC, "R1 reset pc", fetch_pc, RST_PC);
    check(id_instr == 32'h0, "R1 reset id word", id_instr, 32'h0);
    check(!redirect && !flush, "R1 reset redirect", {30'h0, redirect, flush}, 32'h0);
    rst_n = 1'b1;

    // R2 sequential advance
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check(fetch_pc == RST_PC + 32'(4 * k), "R2 pc step", fetch_pc, RST_PC + 32'(4 * k));
      check(id_instr == FILLER, "R2 id capture", id_instr, FILLER);
    end

    // vector table: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      pc_f        = fetch_pc;
      ins         = VEC[i][95:64];
      fetch_instr = ins;
      rs_val      = VEC[i][63:32];
      rt_val      = VEC[i][31:0];
      tk          = exp_take(ins, rs_val, rt_val);
      tgt         = exp_target(pc_f, ins);
      @(negedge clk);
      fetch_instr = FILLER;
      check(id_instr == ins, "R2 branch in decode", id_instr, ins);
      check(redirect == tk, "R3 R4 R5 R8 redirect", {31'h0, redirect}, {31'h0, tk});
      check(flush == redirect, "R9 flush matches", {31'h0, flush}, {31'h0, redirect});
      check(target == tgt, "R6 target", target, tgt);
      @(negedge clk);
      if (tk) begin
        check(fetch_pc == tgt, "R7 pc to target", fetch_pc, tgt);
        check(id_instr == 32'h0, "R7 one bubble", id_instr, 32'h0);
      end else begin
        check(fetch_pc == pc_f + 32'd8, "R5 sequential pc", fetch_pc, pc_f + 32'd8);
        check(id_instr == FILLER, "R5 no bubble", id_instr, FILLER);
      end
    end

    // R7 bubble lasts one cycle only: next decode word is the target fetch
    @(negedge clk);
    fetch_instr = 32'h1000_0001;
    rs_val = 32'd3;
    rt_val = 32'd3;
    pc_f = fetch_pc;
    @(negedge clk);
    fetch_instr = 32'h0011_2233;
    @(negedge clk);
    fetch_instr = FILLER;
    check(id_instr == 32'h0, "R7 bubble", id_instr, 32'h0);
    check(fetch_pc == pc_f + 32'd8, "R7 target fetch", fetch_pc, pc_f + 32'd8);
    @(negedge clk);
    check(id_instr == FILLER, "R7 single bubble", id_instr, FILLER);

    // R1 asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    check(fetch_pc == RST_PC, "R1 async pc", fetch_pc, RST_PC);
    check(id_instr == 32'h0, "R1 async id word", id_instr, 32'h0);
    check(!redirect, "R1 async redirect", {31'h0, redirect}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(fetch_pc == RST_PC + 32'd4, "R2 restart", fetch_pc, RST_PC + 32'd4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule